// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is a 16-bit up/down counter that drives a single symmetric pulse-width-modulated output. The count climbs from zero to a programmable ceiling (TOP), turns around, descends back to zero, and repeats. A compare value sets where the output changes level on each slope. Because the output sets and clears at mirror-image points of the ramp, the pulse stays centred in the period. That suits motor and power-stage control.

A prescaler select chooses how often the counter steps: every clock, or every 8, 64, 256 or 1024 clocks. It can also stop the counter. The host never writes the live period or compare registers directly. Each write lands in a holding copy, and the holding copies are transferred into the live registers at one fixed point of the ramp. A scheme input picks that point: at TOP, or at zero. The second choice keeps every period symmetric even when TOP is changed. TOP itself is taken either from the period register or from the compare register. A two-bit output mode selects forced-low, toggle, non-inverted or inverted output.

Top module: `pwm_dual_slope`

## Requirements
- R1: After a synchronous reset, `cnt` = 0, `cnt_down` = 0 and `pwm_out` = 0. The live and holding period registers hold RST_TOP (0x00FF), and the live and holding compare registers hold 0.
- R2: On each step the count moves by one. Going up, when the count equals or exceeds TOP and is non-zero, the next step goes down and `cnt_down` becomes 1. Going down, the step from 0 goes to 1 with `cnt_down` = 0. TOP and 0 are each held for exactly one step, so a period lasts 2·TOP steps.
- R3: `presc_sel` codes 1, 2, 3, 4 and 5 step the counter every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop it, and `cnt` holds its value while stopped.
- R4: `top_src` = 0 takes TOP from the live period register. `top_src` = 1 takes TOP from the live compare register.
- R5: With `scheme` = 0, host writes change only the holding registers while the counter runs. Both live registers reload from them on the step taken while the count sits at TOP on the up slope.
- R6: With `scheme` = 1, both live registers reload from the holding registers on the step taken while the count is 0.
- R7: While the counter is stopped, the live registers copy the holding registers every clock.
- R8: In `out_mode` = 2 (non-inverted), `pwm_out` goes low when the count reaches the compare value on the up slope, and goes high when it reaches it on the down slope. `pwm_out` updates one clock after the count step. With 0 < C < TOP, the output is high for 2·C of every 2·TOP steps.
- R9: `out_mode` = 3 (inverted) gives the complement of the levels in R8.
- R10: In modes 2 and 3, a compare value of 0 forces the non-inverted level low. A compare value at or above TOP forces it high. Inverted mode gives the opposite levels.
- R11: `out_mode` = 1 with `top_src` = 1 toggles `pwm_out` each time the count equals the compare value, which gives a 50% square wave with a period of 4·TOP steps. `out_mode` = 0, and `out_mode` = 1 with `top_src` = 0, drive `pwm_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Step-rate code (0/6/7 stop, 1..5 divide by 1/8/64/256/1024) |
| scheme | input | 1 | Reload point: 0 at TOP, 1 at zero |
| top_src | input | 1 | TOP source: 0 period register, 1 compare register |
| out_mode | input | 2 | 0 low, 1 toggle, 2 non-inverted, 3 inverted |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_wdata | input | 16 | Period write data |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 16 | Compare write data |
| cnt | output | 16 | Current count |
| cnt_down | output | 1 | 1 while on the down slope |
| pwm_out | output | 1 | Waveform output |

## Verification
The bench writes a new TOP part-way down a slope and then checks the next peak. With scheme 0 the old peak must still appear; with scheme 1 the new one must. A design that reloads at the wrong point would swap those peaks. Compare values of 0, exactly TOP and above TOP are driven in both polarities. A design without the saturation rules would produce a one-step glitch or a stuck wrong level there. The bench measures duty, toggle count and step spacing over whole periods, so an off-by-one in the turnaround or the prescaler shows up as a wrong count. A cycle model also tracks every clock under random mode, rate and write changes.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } outmode_e;

  // Log2 of the step divider for a rate code; run flag tells if it counts.
  function automatic int unsigned rate_shift(input logic [2:0] code);
    case (code)
      3'd1:    rate_shift = 0;
      3'd2:    rate_shift = 3;
      3'd3:    rate_shift = 6;
      3'd4:    rate_shift = 8;
      3'd5:    rate_shift = 10;
      default: rate_shift = 0;
    endcase
  endfunction

  function automatic logic rate_runs(input logic [2:0] code);
    rate_runs = (code >= 3'd1) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       run,
  output logic       tick
);
  import pwmt_pkg::*;

  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] limit;

  always_comb begin
    run   = rate_runs(sel);
    limit = PS_W'((1 << rate_shift(sel)) - 1);
    tick  = run && (div_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_TOP = 16'h00FF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          wr,
  input  logic [1:0][W-1:0]   wdata,
  input  logic                load,
  input  logic                pass,
  output logic [1:0][W-1:0]   act
);
  // Slot 0 is the period register, slot 1 the compare register.
  localparam logic [1:0][W-1:0] RST_VAL = {{W{1'b0}}, RST_TOP};

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [W-1:0] hold_q;
    logic [W-1:0] live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q <= RST_VAL[g];
        live_q <= RST_VAL[g];
      end else begin
        if (load || pass) live_q <= hold_q;
        if (wr[g])        hold_q <= wdata[g];
      end
    end

    assign act[g] = live_q;
  end

endmodule

// File: rtl/pwmt_ramp.sv
module pwmt_ramp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         scheme,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         load
);
  logic up_turn;
  logic at_zero;

  always_comb begin
    at_zero = (cnt == '0);
    up_turn = !down && (cnt >= top_val) && !at_zero;
    load    = tick && (scheme ? at_zero : up_turn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (!down) begin
        if (up_turn) begin
          down <= 1'b1;
          cnt  <= cnt - 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
        end
      end else if (at_zero) begin
        down <= 1'b0;
        cnt  <= W'(1);
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  pwmt_pkg::outmode_e mode,
  input  logic               src_cmp,
  input  logic [W-1:0]       cnt,
  input  logic               down,
  input  logic [W-1:0]       cmp,
  input  logic [W-1:0]       top_val,
  output logic               pwm
);
  import pwmt_pkg::*;

  logic inv;
  logic hit;
  logic nxt;

  always_comb begin
    inv = (mode == OM_INV);
    hit = (cnt == cmp);
    nxt = pwm;
    case (mode)
      OM_OFF:    nxt = 1'b0;
      OM_TOGGLE: nxt = src_cmp ? (hit ? !pwm : pwm) : 1'b0;
      default: begin
        if (cmp == '0)            nxt = inv;
        else if (cmp >= top_val)  nxt = !inv;
        else if (hit)             nxt = down ? !inv : inv;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pwm <= 1'b0;
    else if (step) pwm <= nxt;
  end

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int           W       = 16,
  parameter int           PS_W    = 10,
  parameter logic [W-1:0] RST_TOP = 16'h00FF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   presc_sel,
  input  logic         scheme,
  input  logic         top_src,
  input  logic [1:0]   out_mode,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cnt,
  output logic         cnt_down,
  output logic         pwm_out
);
  import pwmt_pkg::*;

  logic             run;
  logic             tick;
  logic             tick_d;
  logic             load;
  logic [1:0][W-1:0] act;
  logic [W-1:0]     per_act;
  logic [W-1:0]     cmp_act;
  logic [W-1:0]     top_eff;

  pwmt_prescale #(.PS_W(PS_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .sel (presc_sel),
    .run (run),
    .tick(tick)
  );

  pwmt_regs #(.W(W), .RST_TOP(RST_TOP)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .wr   ({cmp_wr, per_wr}),
    .wdata({cmp_wdata, per_wdata}),
    .load (load),
    .pass (!run),
    .act  (act)
  );

  assign per_act = act[0];
  assign cmp_act = act[1];
  assign top_eff = top_src ? cmp_act : per_act;

  pwmt_ramp #(.W(W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .scheme (scheme),
    .top_val(top_eff),
    .cnt    (cnt),
    .down   (cnt_down),
    .load   (load)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_d <= 1'b0;
    else     tick_d <= tick;
  end

  pwmt_wave #(.W(W)) u_wave (
    .clk    (clk),
    .rst    (rst),
    .step   (tick_d),
    .mode   (outmode_e'(out_mode)),
    .src_cmp(top_src),
    .cnt    (cnt),
    .down   (cnt_down),
    .cmp    (cmp_act),
    .top_val(top_eff),
    .pwm    (pwm_out)
  );

endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         scheme,
  input logic [1:0]   out_mode,
  input logic [W-1:0] cnt,
  input logic         cnt_down,
  input logic         pwm_out,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] top_eff,
  input logic         wave_step
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2: count moves by at most one per clock
  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1))));

  // R2: leaving the bottom always goes to one on the up slope
  p_bottom_turn_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $fell(cnt_down) |-> ($past(cnt) == '0 && cnt == W'(1)));

  // R3: a stopped counter holds its value
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !run |=> $stable(cnt));

  // R5: with reload at TOP, the live compare only changes on the TOP step
  p_top_reload_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(run) && !$past(scheme) && cmp_act != $past(cmp_act))
      |-> (!$past(cnt_down) && $past(cnt) >= $past(top_eff)));

  // R6: with reload at zero, the live compare only changes on the zero step
  p_zero_reload_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(run) && $past(scheme) && cmp_act != $past(cmp_act)) |-> ($past(cnt) == '0));

  // R10: saturation levels in non-inverted mode
  p_sat_low_r10: assert property (@(posedge clk) disable iff (rst)
    (wave_step && out_mode == 2'd2 && cmp_act == '0) |=> !pwm_out);

  p_sat_high_r10: assert property (@(posedge clk) disable iff (rst)
    (wave_step && out_mode == 2'd2 && cmp_act != '0 && cmp_act >= top_eff) |=> pwm_out);

  // R11: mode 0 drives the output low
  p_off_low_r11: assert property (@(posedge clk) disable iff (rst)
    (wave_step && out_mode == 2'd0) |=> !pwm_out);

endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .scheme   (scheme),
  .out_mode (out_mode),
  .cnt      (cnt),
  .cnt_down (cnt_down),
  .pwm_out  (pwm_out),
  .cmp_act  (cmp_act),
  .top_eff  (top_eff),
  .wave_step(tick_d)
);

// File: tb/pwm_dual_slope_bench.sv
`timescale 1ns/1ps
module pwm_dual_slope_bench;
  localparam int W = 16;
  localparam logic [W-1:0] RST_TOP = 16'h00FF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   presc_sel = 3'd0;
  logic         scheme = 1'b0;
  logic         top_src = 1'b0;
  logic [1:0]   out_mode = 2'd0;
  logic         per_wr = 1'b0;
  logic [W-1:0] per_wdata = '0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] cnt;
  logic         cnt_down;
  logic         pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  pwm_dual_slope u_pwm_dual_slope (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .scheme(scheme),
    .top_src(top_src), .out_mode(out_mode), .per_wr(per_wr),
    .per_wdata(per_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cnt(cnt), .cnt_down(cnt_down), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int divider(input logic [2:0] code);
    case (code)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  // Cycle model built from the requirements.
  int       m_ps;
  logic [W-1:0] m_cnt, m_pb, m_cb, m_pa, m_ca;
  logic     m_dir, m_out, m_td;
  logic [1:0] m_mode;

  always @(posedge clk) begin
    int  n;
    bit  tk, ld, upt;
    logic [W-1:0] t;
    if (rst) begin
      m_ps = 0; m_cnt = '0; m_dir = 0; m_out = 0; m_td = 0;
      m_pb = RST_TOP; m_pa = RST_TOP; m_cb = '0; m_ca = '0; m_mode = 2'd0;
    end else begin
      n  = divider(presc_sel);
      tk = (n != 0) && (m_ps >= n - 1);
      t  = top_src ? m_ca : m_pa;
      if (m_td) begin
        if (out_mode == 2'd0) m_out = 0;
        else if (out_mode == 2'd1) m_out = top_src ? ((m_cnt == m_ca) ? !m_out : m_out) : 1'b0;
        else if (m_ca == '0) m_out = (out_mode == 2'd3);
        else if (m_ca >= t) m_out = (out_mode == 2'd2);
        else if (m_cnt == m_ca) m_out = m_dir ^ (out_mode == 2'd3);
      end
      upt = !m_dir && (m_cnt >= t) && (m_cnt != '0);
      ld  = tk && (scheme ? (m_cnt == '0) : upt);
      if (tk) begin
        if (!m_dir) begin
          if (upt) begin m_dir = 1; m_cnt = m_cnt - 1'b1; end
          else m_cnt = m_cnt + 1'b1;
        end else if (m_cnt == '0) begin m_dir = 0; m_cnt = 1; end
        else m_cnt = m_cnt - 1'b1;
      end
      if (ld || n == 0) begin m_pa = m_pb; m_ca = m_cb; end
      if (per_wr) m_pb = per_wdata;
      if (cmp_wr) m_cb = cmp_wdata;
      m_ps = (n == 0) ? 0 : (tk ? 0 : m_ps + 1);
      m_td = tk;
      m_mode = out_mode;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst && !done) begin
      chk("R2 model count", int'(cnt), int'(m_cnt));
      chk("R2 model direction", int'(cnt_down), int'(m_dir));
      case (m_mode)
        2'd2: chk("R8 model output", int'(pwm_out), int'(m_out));
        2'd3: chk("R9 model output", int'(pwm_out), int'(m_out));
        default: chk("R11 model output", int'(pwm_out), int'(m_out));
      endcase
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] sel, input logic sch, input logic src,
                       input logic [1:0] md, input int per, input int cv);
    @(negedge clk);
    presc_sel = 3'd0;
    per_wr = 1; per_wdata = W'(per);
    cmp_wr = 1; cmp_wdata = W'(cv);
    @(negedge clk);
    per_wr = 0; cmp_wr = 0;
    cyc(2);
    scheme = sch; top_src = src; out_mode = md; presc_sel = sel;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (cnt != '0);
  endtask

  task automatic peak(input int k, output int mx);
    mx = 0;
    repeat (k) begin
      @(negedge clk);
      if (int'(cnt) > mx) mx = int'(cnt);
    end
  endtask

  task automatic high_count(input int k, output int h);
    h = 0;
    repeat (k) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic edge_count(input int k, input bit use_pwm, output int e);
    logic [W-1:0] pc;
    logic pp;
    e = 0; pc = cnt; pp = pwm_out;
    repeat (k) begin
      @(negedge clk);
      if (use_pwm) begin if (pwm_out != pp) e++; end
      else if (cnt != pc) e++;
      pc = cnt; pp = pwm_out;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_1234));
    cyc(3);
    rst = 0;
    @(negedge clk);
    chk("R1 reset count", int'(cnt), 0);
    chk("R1 reset direction", int'(cnt_down), 0);
    chk("R1 reset output", int'(pwm_out), 0);
    cmp_en = 1;

    // R7 and R2: stopped writes pass straight through; peak and half period
    setup(3'd1, 1'b0, 1'b0, 2'd2, 10, 4);
    wait_zero();
    peak(16, v);
    chk("R7 passthrough peak", v, 10);
    wait_zero();
    v = 0;
    do begin @(negedge clk); v++; end while (cnt != '0);
    chk("R2 period steps", v, 20);

    // R4: compare register as TOP
    setup(3'd1, 1'b0, 1'b1, 2'd2, 30, 12);
    wait_zero();
    peak(30, v);
    chk("R4 compare-sourced TOP", v, 12);

    // R8 / R9 duty
    setup(3'd1, 1'b0, 1'b0, 2'd2, 20, 5);
    wait_zero(); cyc(40);
    high_count(40, v);
    chk("R8 non-inverted duty", v, 10);
    @(negedge clk); out_mode = 2'd3;
    cyc(40);
    high_count(40, v);
    chk("R9 inverted duty", v, 30);

    // R10 saturation
    setup(3'd1, 1'b0, 1'b0, 2'd2, 20, 0);
    wait_zero(); cyc(40);
    high_count(40, v);
    chk("R10 compare zero low", v, 0);
    @(negedge clk); out_mode = 2'd3;
    cyc(3);
    high_count(40, v);
    chk("R10 compare zero inverted high", v, 40);
    setup(3'd1, 1'b0, 1'b0, 2'd2, 20, 20);
    wait_zero(); cyc(3);
    high_count(40, v);
    chk("R10 compare at TOP high", v, 40);
    setup(3'd1, 1'b0, 1'b0, 2'd3, 20, 25);
    wait_zero(); cyc(3);
    high_count(40, v);
    chk("R10 compare above TOP inverted low", v, 0);

    // R11 toggle and forced low
    setup(3'd1, 1'b0, 1'b1, 2'd1, 50, 6);
    wait_zero(); cyc(12);
    edge_count(48, 1'b1, v);
    chk("R11 toggle edges", v, 4);
    @(negedge clk); out_mode = 2'd0;
    cyc(3);
    high_count(20, v);
    chk("R11 mode zero low", v, 0);
    @(negedge clk); out_mode = 2'd1; top_src = 1'b0;
    cyc(3);
    high_count(20, v);
    chk("R11 toggle with period TOP low", v, 0);

    // R3 step rate and stop
    setup(3'd2, 1'b0, 1'b0, 2'd2, 4, 2);
    wait_zero();
    edge_count(160, 1'b0, v);
    chk("R3 divide by 8 steps", v, 20);
    @(negedge clk); presc_sel = 3'd0;
    edge_count(20, 1'b0, v);
    chk("R3 code 0 stopped", v, 0);
    @(negedge clk); presc_sel = 3'd6;
    edge_count(20, 1'b0, v);
    chk("R3 code 6 stopped", v, 0);

    // R5: reload at TOP keeps the old peak once more
    setup(3'd1, 1'b0, 1'b0, 2'd2, 20, 5);
    wait_zero();
    do @(negedge clk); while (!(cnt == 16'd15 && cnt_down));
    per_wr = 1; per_wdata = 16'd8;
    @(negedge clk); per_wr = 0;
    wait_zero();
    peak(30, v);
    chk("R5 peak after mid-slope write", v, 20);

    // R6: reload at zero uses the new peak at once
    setup(3'd1, 1'b1, 1'b0, 2'd2, 20, 5);
    wait_zero();
    do @(negedge clk); while (!(cnt == 16'd15 && cnt_down));
    per_wr = 1; per_wdata = 16'd8;
    @(negedge clk); per_wr = 0;
    wait_zero();
    peak(30, v);
    chk("R6 peak after mid-slope write", v, 8);

    // Random segments against the model
    for (int s = 0; s < 250; s++) begin
      int r, len;
      logic src;
      logic [2:0] sel;
      src = 1'($urandom % 2);
      r = int'($urandom % 10);
      if (r < 6) sel = 3'd1;
      else if (r == 6) sel = 3'd2;
      else if (r == 7) sel = 3'd3;
      else if (r == 8) sel = 3'd0;
      else sel = 3'd6 + 3'($urandom % 2);
      setup(sel, 1'($urandom % 2), src, 2'($urandom % 4),
            3 + int'($urandom % 38),
            src ? 3 + int'($urandom % 38) : int'($urandom % 46));
      len = 50 + int'($urandom % 250);
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        per_wr = 0; cmp_wr = 0;
        if ($urandom % 30 == 0) begin per_wr = 1; per_wdata = W'(3 + $urandom % 38); end
        if ($urandom % 30 == 0) begin
          cmp_wr = 1;
          cmp_wdata = src ? W'(3 + $urandom % 38) : W'($urandom % 46);
        end
        if ($urandom % 60 == 0) out_mode = 2'($urandom % 4);
        if ($urandom % 80 == 0) scheme = ~scheme;
      end
      @(negedge clk); per_wr = 0; cmp_wr = 0;
    end

    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule